// File: doc/BRIEF.md
# Receive frame queue screener

The screener sorts each received Ethernet frame into one of sixteen receive queues and can mark it for dropping. Frame bytes arrive as a stream, one byte per accepted beat, with a start marker on the first byte and an end marker on the last. While the frame streams past, the block keeps only the bytes its rules need. One cycle after the end marker it presents a queue number, a drop flag and a one-cycle valid strobe.

There are two rule classes. A type-1 rule can test the UDP destination port and the DS/TC byte of an IPv4 header. A type-2 rule can test the EtherType against a small table, and can apply up to three masked 16-bit compares. Each compare uses an entry of a compare table, and that entry places its 16-bit window at a byte offset counted from one of four bases. A rule hits only when at least one of its enabled tests matches and none of them fails. All rules and tables are loaded through a plain write port. The VLAN fields of the type-2 rule word and the VLAN-ID bit of a compare entry are stored but have no effect.

The stream input never applies back-pressure: `s_ready` is always high, and every cycle with `s_valid` high is a beat. Rules should be held stable while a frame is streaming. The decision output has no ready and must be taken in the cycle it is presented.

Top module: `rx_queue_screener`

## Requirements
- R1: After reset, `dec_valid`, `dec_queue` and `dec_drop` are 0 and every rule and table word is 0, so a frame sent before any write is given queue 0 with no drop.
- R2: `s_ready` is always 1. The beat with `s_sof` is frame byte 0, and each later beat is the next byte. `dec_valid` is high for exactly the one cycle after the beat that carries `s_eof`, and `dec_queue`/`dec_drop` are 0 whenever `dec_valid` is low.
- R3: Type-1 word: queue in [3:0], DS/TC value in [11:4], UDP port value in [27:12], DS/TC test enable in [28], port test enable in [29], drop in [30]. The port test compares {byte 36, byte 37}, and the DS/TC test compares byte 15.
- R4: A rule hits when at least one enabled test matches and no enabled test mismatches. A rule with no test enabled never hits.
- R5: Every type-1 rule takes precedence over every type-2 rule. Within a class the lowest-indexed hitting rule wins. With no hit the queue is 0 and drop is 0.
- R6: Type-2 word: queue in [3:0], EtherType index in [11:9], EtherType enable in [12], compare A index/enable in [17:13]/[18], B in [23:19]/[24], C in [29:25]/[30], drop in [31]. The EtherType test compares {byte 12, byte 13} with the selected table entry.
- R7: Compare entry word 0 holds the mask in [15:0] and the value in [31:16]. Word 1 holds the offset in [6:0], the mode in [8:7] and a mask-off bit in [9]. The test matches when (frame value & mask) equals (value & mask), and the mask counts as 16'hFFFF when [9] is set.
- R8: The 16-bit frame value is {byte P, byte P+1}, where P is the offset plus a base: 0 for mode 0, 14 for mode 1, 34 for mode 2, 42 for mode 3.
- R9: An enabled EtherType or compare index at or above the number of table entries makes that test a mismatch.
- R10: `dec_drop` is the drop bit of the winning rule.
- R11: Write address: region [7:6] (0 type-1 rule, 1 type-2 rule, 2 EtherType entry taking data [15:0], 3 compare entry) and index [5:0]. For compare entries the entry is [5:1] and the word is [0]. A write to an index beyond the implemented count changes nothing.
- R12: A byte position the frame did not reach reads as 0 in every test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Always 1, no back-pressure |
| s_data | input | 8 | Frame byte |
| s_sof | input | 1 | First byte of frame |
| s_eof | input | 1 | Last byte of frame |
| cfg_we | input | 1 | Rule/table write strobe |
| cfg_addr | input | 8 | Write address (region and index) |
| cfg_wdata | input | 32 | Write data |
| dec_valid | output | 1 | Decision strobe |
| dec_queue | output | 4 | Selected queue |
| dec_drop | output | 1 | Drop the frame |

## Verification
Directed frames separate the cases the rules are meant to tell apart. Two type-1 rules hit the same port, which exposes the lowest-index priority. A DS/TC mismatch vetoes a port match. A type-1 hit wins over a type-2 hit. Each of the four offset modes is placed on a window whose low byte differs from the compare value, so only the mask makes it match. The mask-off bit turns that same case into a miss. An out-of-range compare index kills an otherwise good rule. A short frame shows that bytes left over from the previous, longer frame do not survive. Random rounds then load every rule and table from a small value alphabet, so that partial matches, vetoes and out-of-range indices are common, and compare each decision with a bench model.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int QW = 4;

  localparam logic [1:0] RGN_T1  = 2'd0;
  localparam logic [1:0] RGN_T2  = 2'd1;
  localparam logic [1:0] RGN_ET  = 2'd2;
  localparam logic [1:0] RGN_CMP = 2'd3;

  localparam logic [7:0] POS_ETYPE = 8'd12;
  localparam logic [7:0] POS_DSTC  = 8'd15;
  localparam logic [7:0] POS_UDP   = 8'd36;

  typedef struct packed {
    logic          spare;
    logic          drop;
    logic          port_en;
    logic          dstc_en;
    logic [15:0]   port;
    logic [7:0]    dstc;
    logic [QW-1:0] queue;
  } t1_rule_t;

  typedef struct packed {
    logic          drop;
    logic          c_en;
    logic [4:0]    c_idx;
    logic          b_en;
    logic [4:0]    b_idx;
    logic          a_en;
    logic [4:0]    a_idx;
    logic          et_en;
    logic [2:0]    et_idx;
    logic          vlan_en;
    logic          spare;
    logic [2:0]    vlan_pri;
    logic [QW-1:0] queue;
  } t2_rule_t;

  function automatic logic [7:0] mode_base(input logic [1:0] mode);
    case (mode)
      2'd0:    return 8'd0;
      2'd1:    return 8'd14;
      2'd2:    return 8'd34;
      default: return 8'd42;
    endcase
  endfunction
endpackage

// File: rtl/scr_frame_tap.sv
module scr_frame_tap
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        sof,
  input  logic        eof,
  input  logic [7:0]  data,
  output logic [7:0]  pos_o,
  output logic [15:0] etype_o,
  output logic [7:0]  dstc_o,
  output logic [15:0] port_o,
  output logic        done_o
);
  localparam int NTAP = 5;
  localparam logic [7:0] TAP_POS [NTAP] = '{POS_ETYPE, POS_ETYPE + 8'd1, POS_DSTC,
                                            POS_UDP, POS_UDP + 8'd1};

  logic [7:0] cnt;
  logic [7:0] tap [NTAP];

  assign pos_o = sof ? 8'd0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= beat && eof;
      if (beat) cnt <= (pos_o == 8'hFF) ? pos_o : pos_o + 8'd1;
    end
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           tap[g] <= '0;
      else if (beat && pos_o == TAP_POS[g]) tap[g] <= data;
      else if (beat && sof)                 tap[g] <= '0;
    end

    a_r12_tap_capture: assert property (@(posedge clk) disable iff (!rst_n)
      beat && pos_o == TAP_POS[g] |=> tap[g] == $past(data));
  end

  assign etype_o = {tap[0], tap[1]};
  assign dstc_o  = tap[2];
  assign port_o  = {tap[3], tap[4]};

  a_r2_done_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    beat && eof |=> done_o);
endmodule

// File: rtl/scr_cmp_entry.sv
module scr_cmp_entry
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_val,
  input  logic        we_ctl,
  input  logic [31:0] wdata,
  input  logic        beat,
  input  logic        sof,
  input  logic [7:0]  pos,
  input  logic [7:0]  data,
  output logic        hit_o
);
  logic [15:0] mask_q, val_q;
  logic [6:0]  off_q;
  logic [1:0]  mode_q;
  logic        nomask_q;
  logic [7:0]  cap_hi, cap_lo;
  logic [7:0]  hi_pos, lo_pos;
  logic [15:0] eff_mask;

  assign hi_pos = mode_base(mode_q) + {1'b0, off_q};
  assign lo_pos = hi_pos + 8'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; val_q <= '0; off_q <= '0; mode_q <= '0; nomask_q <= 1'b0;
    end else begin
      if (we_val) {val_q, mask_q} <= wdata;
      if (we_ctl) {nomask_q, mode_q, off_q} <= wdata[9:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_hi <= '0;
      cap_lo <= '0;
    end else if (beat) begin
      if (pos == hi_pos)  cap_hi <= data;
      else if (sof)       cap_hi <= '0;
      if (pos == lo_pos)  cap_lo <= data;
      else if (sof)       cap_lo <= '0;
    end
  end

  assign eff_mask = nomask_q ? 16'hFFFF : mask_q;
  assign hit_o    = (({cap_hi, cap_lo} & eff_mask) == (val_q & eff_mask));

  a_r8_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    beat && pos == hi_pos |=> cap_hi == $past(data));
  a_r8_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
    beat && pos == lo_pos |=> cap_lo == $past(data));
endmodule

// File: rtl/scr_rule_pick.sv
module scr_rule_pick
  import scr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          hit_i,
  input  logic [N-1:0][QW-1:0]  q_i,
  input  logic [N-1:0]          drop_i,
  output logic                  any_o,
  output logic [QW-1:0]         q_o,
  output logic                  drop_o
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic [SW-1:0] sel;

  always_comb begin
    sel   = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel   = SW'(i);
        any_o = 1'b1;
      end
    end
  end

  assign q_o    = any_o ? q_i[sel] : '0;
  assign drop_o = any_o && drop_i[sel];

  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> hit_i[sel] && ((hit_i & ((N'(1) << sel) - N'(1))) == '0));
  a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> hit_i == '0);
endmodule

// File: rtl/rx_queue_screener.sv
module rx_queue_screener
  import scr_pkg::*;
#(
  parameter int N_T1  = 4,
  parameter int N_T2  = 4,
  parameter int N_ET  = 8,
  parameter int N_CMP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          dec_valid,
  output logic [QW-1:0] dec_queue,
  output logic          dec_drop
);
  logic [1:0] rgn;
  logic [5:0] low;
  assign rgn = cfg_addr[7:6];
  assign low = cfg_addr[5:0];

  t1_rule_t    t1_w   [N_T1];
  t2_rule_t    t2_w   [N_T2];
  logic [15:0] et_tab [N_ET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_T1; i++) t1_w[i]   <= '0;
      for (int i = 0; i < N_T2; i++) t2_w[i]   <= '0;
      for (int i = 0; i < N_ET; i++) et_tab[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_T1; i++)
        if (rgn == RGN_T1 && low == 6'(i)) t1_w[i] <= t1_rule_t'(cfg_wdata);
      for (int i = 0; i < N_T2; i++)
        if (rgn == RGN_T2 && low == 6'(i)) t2_w[i] <= t2_rule_t'(cfg_wdata);
      for (int i = 0; i < N_ET; i++)
        if (rgn == RGN_ET && low == 6'(i)) et_tab[i] <= cfg_wdata[15:0];
    end
  end

  logic        beat, done;
  logic [7:0]  pos;
  logic [15:0] cap_et, cap_port;
  logic [7:0]  cap_dstc;

  assign s_ready = 1'b1;
  assign beat    = s_valid;

  scr_frame_tap u_tap (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof), .eof(s_eof), .data(s_data),
    .pos_o(pos), .etype_o(cap_et), .dstc_o(cap_dstc), .port_o(cap_port), .done_o(done)
  );

  logic [N_CMP-1:0] cmp_hit;
  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    logic sel_entry;
    assign sel_entry = cfg_we && rgn == RGN_CMP && low[5:1] == 5'(g);
    scr_cmp_entry u_cmp (
      .clk(clk), .rst_n(rst_n),
      .we_val(sel_entry && !low[0]), .we_ctl(sel_entry && low[0]), .wdata(cfg_wdata),
      .beat(beat), .sof(s_sof), .pos(pos), .data(s_data), .hit_o(cmp_hit[g])
    );
  end

  logic [N_T1-1:0]         t1_hit, t1_drop;
  logic [N_T1-1:0][QW-1:0] t1_q;
  always_comb begin
    logic ok, bad;
    for (int i = 0; i < N_T1; i++) begin
      ok  = (t1_w[i].port_en && t1_w[i].port == cap_port) ||
            (t1_w[i].dstc_en && t1_w[i].dstc == cap_dstc);
      bad = (t1_w[i].port_en && t1_w[i].port != cap_port) ||
            (t1_w[i].dstc_en && t1_w[i].dstc != cap_dstc);
      t1_hit[i]  = ok && !bad;
      t1_drop[i] = t1_w[i].drop;
      t1_q[i]    = t1_w[i].queue;
    end
  end

  logic [N_T2-1:0]         t2_hit, t2_drop;
  logic [N_T2-1:0][QW-1:0] t2_q;
  always_comb begin
    logic [3:0] en, res;
    for (int i = 0; i < N_T2; i++) begin
      en  = {t2_w[i].c_en, t2_w[i].b_en, t2_w[i].a_en, t2_w[i].et_en};
      res = '0;
      for (int k = 0; k < N_ET; k++)
        if (t2_w[i].et_idx == 3'(k)) res[0] = (et_tab[k] == cap_et);
      for (int k = 0; k < N_CMP; k++) begin
        if (t2_w[i].a_idx == 5'(k)) res[1] = cmp_hit[k];
        if (t2_w[i].b_idx == 5'(k)) res[2] = cmp_hit[k];
        if (t2_w[i].c_idx == 5'(k)) res[3] = cmp_hit[k];
      end
      t2_hit[i]  = (|(en & res)) && !(|(en & ~res));
      t2_drop[i] = t2_w[i].drop;
      t2_q[i]    = t2_w[i].queue;
    end
  end

  logic          t1_any, t2_any, t1_d, t2_d;
  logic [QW-1:0] t1_sel_q, t2_sel_q;

  scr_rule_pick #(.N(N_T1)) u_pick1 (
    .clk(clk), .rst_n(rst_n), .hit_i(t1_hit), .q_i(t1_q), .drop_i(t1_drop),
    .any_o(t1_any), .q_o(t1_sel_q), .drop_o(t1_d)
  );
  scr_rule_pick #(.N(N_T2)) u_pick2 (
    .clk(clk), .rst_n(rst_n), .hit_i(t2_hit), .q_i(t2_q), .drop_i(t2_drop),
    .any_o(t2_any), .q_o(t2_sel_q), .drop_o(t2_d)
  );

  assign dec_valid = done;
  always_comb begin
    dec_queue = '0;
    dec_drop  = 1'b0;
    if (done) begin
      if (t1_any) begin
        dec_queue = t1_sel_q;
        dec_drop  = t1_d;
      end else if (t2_any) begin
        dec_queue = t2_sel_q;
        dec_drop  = t2_d;
      end
    end
  end

  logic cfg_unused;
  always_comb begin
    cfg_unused = 1'b0;
    for (int i = 0; i < N_T1; i++) cfg_unused ^= t1_w[i].spare;
    for (int i = 0; i < N_T2; i++)
      cfg_unused ^= ^{t2_w[i].vlan_en, t2_w[i].spare, t2_w[i].vlan_pri};
  end

  a_r2_valid_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(s_valid && s_eof));
  a_r5_default_queue: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !t1_any && !t2_any |-> dec_queue == '0 && !dec_drop);
  a_r10_drop_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
    dec_drop |-> dec_valid && (t1_any || t2_any));
endmodule

// File: tb/rx_queue_screener_test.sv
module rx_queue_screener_test;
  localparam int NT1 = 4, NT2 = 4, NET = 8, NCMP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_valid, dec_drop;
  logic [3:0]  dec_queue;

  always #5 clk = ~clk;

  rx_queue_screener #(.N_T1(NT1), .N_T2(NT2), .N_ET(NET), .N_CMP(NCMP)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_queue(dec_queue), .dec_drop(dec_drop)
  );

  logic [31:0] m_t1 [NT1];
  logic [31:0] m_t2 [NT2];
  logic [15:0] m_et [NET];
  logic [31:0] m_cw0 [NCMP];
  logic [31:0] m_cw1 [NCMP];
  logic [7:0]  fb [256];
  int          flen;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] fbyte(input int p);
    return (p < flen && p < 256) ? fb[p] : 8'h00;
  endfunction

  function automatic bit cmp_ok(input logic [4:0] k);
    logic [31:0] c0, c1;
    int base, p;
    logic [15:0] m;
    if (int'(k) >= NCMP) return 0;
    c0 = m_cw0[k];
    c1 = m_cw1[k];
    case (c1[8:7])
      2'd0: base = 0;
      2'd1: base = 14;
      2'd2: base = 34;
      default: base = 42;
    endcase
    p = base + int'(c1[6:0]);
    m = c1[9] ? 16'hFFFF : c0[15:0];
    return (({fbyte(p), fbyte(p + 1)} & m) == (c0[31:16] & m));
  endfunction

  function automatic logic [4:0] model();
    logic [31:0] w;
    bit ok, bad, r;
    for (int i = 0; i < NT1; i++) begin
      w = m_t1[i]; ok = 0; bad = 0;
      if (w[29]) begin
        if ({fbyte(36), fbyte(37)} == w[27:12]) ok = 1; else bad = 1;
      end
      if (w[28]) begin
        if (fbyte(15) == w[11:4]) ok = 1; else bad = 1;
      end
      if (ok && !bad) return {w[30], w[3:0]};
    end
    for (int i = 0; i < NT2; i++) begin
      w = m_t2[i]; ok = 0; bad = 0;
      if (w[12]) begin
        r = (int'(w[11:9]) < NET) && (m_et[w[11:9]] == {fbyte(12), fbyte(13)});
        if (r) ok = 1; else bad = 1;
      end
      for (int j = 0; j < 3; j++) begin
        if (w[18 + 6 * j]) begin
          if (cmp_ok(w[13 + 6 * j +: 5])) ok = 1; else bad = 1;
        end
      end
      if (ok && !bad) return {w[31], w[3:0]};
    end
    return 5'd0;
  endfunction

  task automatic cfg(input logic [7:0] a, input logic [31:0] d);
    int lo;
    lo = int'(a[5:0]);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a[7:6])
      2'd0: if (lo < NT1) m_t1[lo] = d;
      2'd1: if (lo < NT2) m_t2[lo] = d;
      2'd2: if (lo < NET) m_et[lo] = d[15:0];
      default: if ((lo >> 1) < NCMP) begin
        if (lo[0]) m_cw1[lo >> 1] = d; else m_cw0[lo >> 1] = d;
      end
    endcase
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NT1; i++) cfg({2'd0, 6'(i)}, 32'h0);
    for (int i = 0; i < NT2; i++) cfg({2'd1, 6'(i)}, 32'h0);
    for (int i = 0; i < NET; i++) cfg({2'd2, 6'(i)}, 32'h0);
    for (int i = 0; i < NCMP; i++) begin
      cfg({2'd3, 5'(i), 1'b0}, 32'h0);
      cfg({2'd3, 5'(i), 1'b1}, 32'h0);
    end
  endtask

  task automatic clear_frame(input int len);
    for (int p = 0; p < 256; p++) fb[p] = 8'h00;
    flen = len;
  endtask

  task automatic run_frame(input string req);
    logic [4:0] e;
    for (int b = 0; b < flen; b++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fb[b]; s_sof = (b == 0); s_eof = (b == flen - 1);
      if (b == 1) check(s_ready == 1'b1, "R2 ready", 32'(s_ready), 32'h1);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    e = model();
    check(dec_valid == 1'b1, "R2 strobe", 32'(dec_valid), 32'h1);
    check(dec_queue == e[3:0], {req, " queue"}, 32'(dec_queue), 32'(e[3:0]));
    check(dec_drop == e[4], {req, " drop"}, 32'(dec_drop), 32'(e[4]));
    @(negedge clk);
    check(dec_valid == 1'b0 && dec_queue == 4'd0 && dec_drop == 1'b0, "R2 pulse",
          {dec_valid, dec_drop, dec_queue}, 32'h0);
  endtask

  function automatic logic [7:0] pick8();
    case ($urandom % 5)
      0: return 8'h00;
      1: return 8'h12;
      2: return 8'h34;
      3: return 8'h08;
      default: return 8'h20;
    endcase
  endfunction

  function automatic logic [15:0] pickmask();
    case ($urandom % 4)
      0: return 16'hFFFF;
      1: return 16'hFF00;
      2: return 16'h00FF;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] w, c0, c1;
    int base;
    void'($urandom(32'h5C3EE7));
    for (int i = 0; i < NT1; i++) m_t1[i] = '0;
    for (int i = 0; i < NT2; i++) m_t2[i] = '0;
    for (int i = 0; i < NET; i++) m_et[i] = '0;
    for (int i = 0; i < NCMP; i++) begin m_cw0[i] = '0; m_cw1[i] = '0; end
    clear_frame(40);

    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0 && dec_queue == 4'd0 && dec_drop == 1'b0, "R1 reset outputs",
          {dec_valid, dec_drop, dec_queue}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid == 1'b0, "R1 idle after reset", 32'(dec_valid), 32'h0);

    // R1: untouched rules give queue 0
    for (int p = 0; p < 40; p++) fb[p] = 8'(p * 7 + 1);
    run_frame("R1 default rules");

    // R3: port test, R5: lower index wins
    clear_frame(48);
    fb[36] = 8'h12; fb[37] = 8'h34; fb[15] = 8'h20;
    cfg({2'd0, 6'd2}, (32'h1 << 29) | (32'h1234 << 12) | 32'd5);
    run_frame("R3 port match");
    cfg({2'd0, 6'd1}, (32'h1 << 29) | (32'h1234 << 12) | 32'd3);
    run_frame("R5 lowest index");
    // R4: enabled DS/TC mismatch vetoes rule 0's port match
    cfg({2'd0, 6'd0}, (32'h3 << 28) | (32'h1234 << 12) | (32'h99 << 4) | 32'd7);
    run_frame("R4 veto");
    cfg({2'd0, 6'd0}, (32'h1 << 28) | (32'h20 << 4) | 32'd6);
    run_frame("R3 dstc match");

    // R6: EtherType; R5: class order
    clear_cfg();
    clear_frame(50);
    fb[12] = 8'h08; fb[13] = 8'h00;
    cfg({2'd2, 6'd2}, 32'h0800);
    cfg({2'd2, 6'd3}, 32'h86DD);
    cfg({2'd1, 6'd0}, (32'h1 << 12) | (32'd3 << 9) | 32'd8);
    cfg({2'd1, 6'd1}, (32'h1 << 12) | (32'd2 << 9) | 32'd9);
    run_frame("R6 ethertype");
    fb[36] = 8'h55; fb[37] = 8'h66;
    cfg({2'd0, 6'd3}, (32'h1 << 29) | (32'h5566 << 12) | 32'd4);
    run_frame("R5 type-1 first");

    // R8: each offset mode, R7: mask
    for (int m = 0; m < 4; m++) begin
      clear_cfg();
      clear_frame(70);
      base = (m == 0) ? 0 : (m == 1) ? 14 : (m == 2) ? 34 : 42;
      fb[base + 3] = 8'hA5; fb[base + 4] = 8'h5A;
      cfg({2'd3, 5'd1, 1'b0}, {16'hA577, 16'hFF00});
      cfg({2'd3, 5'd1, 1'b1}, (32'(m) << 7) | 32'd3);
      cfg({2'd1, 6'd0}, (32'h1 << 18) | (32'd1 << 13) | 32'(m + 1));
      run_frame("R8 offset mode");
    end
    // R7: mask-off bit makes the low byte count
    cfg({2'd3, 5'd1, 1'b1}, (32'h1 << 9) | (32'd3 << 7) | 32'd3);
    run_frame("R7 mask off");
    cfg({2'd3, 5'd1, 1'b0}, {16'hA55A, 16'h0000});
    run_frame("R7 exact compare");
    // R10: drop bit of winner
    cfg({2'd1, 6'd0}, (32'h1 << 31) | (32'h1 << 18) | (32'd1 << 13) | 32'd11);
    run_frame("R10 drop");
    // R9: out-of-range compare index
    cfg({2'd1, 6'd0}, (32'h1 << 24) | (32'd20 << 19) | (32'h1 << 18) | (32'd1 << 13) | 32'd11);
    run_frame("R9 range");

    // R12: short frame after a long one, port reads as zero
    clear_cfg();
    clear_frame(60);
    fb[36] = 8'hAB; fb[37] = 8'hCD;
    run_frame("R12 long frame");
    cfg({2'd0, 6'd1}, (32'h1 << 29) | 32'd12);
    clear_frame(20);
    run_frame("R12 short frame");

    // R11: write beyond the type-1 count is ignored
    clear_cfg();
    clear_frame(40);
    cfg({2'd0, 6'd4}, (32'h1 << 29) | 32'd13);
    run_frame("R11 ignored index");
    check(dec_queue == 4'd0, "R11 no alias", 32'(dec_queue), 32'h0);

    for (int it = 0; it < 250; it++) begin
      for (int i = 0; i < NT1; i++) begin
        w = $urandom;
        w[27:12] = ($urandom % 2) ? 16'h1234 : 16'h0000;
        w[11:4]  = ($urandom % 2) ? 8'h20 : 8'h00;
        cfg({2'd0, 6'(i)}, w);
      end
      for (int i = 0; i < NT2; i++) begin
        w = $urandom;
        w[17:13] = 5'($urandom % 10);
        w[23:19] = 5'($urandom % 10);
        w[29:25] = 5'($urandom % 10);
        cfg({2'd1, 6'(i)}, w);
      end
      for (int k = 0; k < NET; k++) cfg({2'd2, 6'(k)}, ($urandom % 2) ? 32'h0800 : 32'h0);
      for (int k = 0; k < NCMP; k++) begin
        c0 = {pick8(), pick8(), pickmask()};
        c1 = $urandom;
        c1[6:0] = 7'($urandom % 24);
        cfg({2'd3, 5'(k), 1'b0}, c0);
        cfg({2'd3, 5'(k), 1'b1}, c1);
      end
      flen = 20 + int'($urandom % 60);
      for (int p = 0; p < 256; p++) fb[p] = (p < flen) ? pick8() : 8'h00;
      run_frame("R4 R5 random");
    end

    summary();
  end
endmodule